// File: doc/BRIEF.md
# Seven-to-one pixel serializer with half-rate edge streams

This block turns a parallel pixel word (three colour channels, a line sync, a frame sync and an active-video flag) into serial lane data for a display link. Each pixel becomes seven serial bits on every data lane. A fourth lane carries a pixel-rate clock pattern that marks where each pixel's bits begin. The block runs on a clock at 3.5 times the pixel rate. Every lane is presented as a pair of half-rate streams, one for the rising edge and one for the falling edge of a downstream double-data-rate output register. Because one pixel spans three and a half cycles, the first bit of successive pixels falls alternately into the rising and falling streams.

The block asks for pixel words itself: `word_take` pulses in the cycle whose closing edge latches the parallel inputs and the mapping select. Two lane mappings are available. A pass-through control forwards a received set of half-rate streams unchanged, including the clock lane, and the parallel input then has no effect on the outputs.

A seven-state phase machine (PH0 to PH6) steps once per cycle. PH0 goes to PH1, PH1 to PH2, and so on through PH5 to PH6, and PH6 returns to PH0. Any illegal encoding goes to PH0. The first word of each pair is taken in PH6 and the second in PH2. The machine keeps running during reset, so the clock lane never stops.

Top module: `pix7_serializer`

## Requirements
- R1: Serial order is the rising-stream bit and then the falling-stream bit of each cycle. Each data lane carries seven bits per pixel slot, bit 0 first, and slots follow one another with no gap. A slot that starts on a rising-stream bit is followed by one that starts on a falling-stream bit, and the reverse.
- R2: `word_take` is high for exactly one cycle at a time. The spacing between successive pulses alternates between 3 and 4 cycles, and `word_take` is never high while `rst` is high.
- R3: With `map_sel`=0 at the take cycle, lane L bit k carries F[7L+k]. F is the 21-bit vector with F[5:0]=`pix_red`, F[11:6]=`pix_grn`, F[17:12]=`pix_blu`, F[18]=`line_sync`, F[19]=`frame_sync` and F[20]=`active`. Bit positions beyond F carry 0.
- R4: With `map_sel`=1 at the take cycle, lane L bit k carries F[7L+6-k], which reverses the order within each lane.
- R5: The parallel inputs and `map_sel` are sampled only at the edge that closes a `word_take` cycle. Values driven in any other cycle do not appear in any slot.
- R6: Within every slot, the clock lane sends the bits 1,1,0,0,0,1,1 for bit positions 0 to 6. Its 0-to-1 transition therefore comes two bits before bit 0 of the next slot.
- R7: Words appear in slots in the order they were taken. A word taken when N serial bits have been observed starts in the first slot that begins at serial index N+2 or later, which is index N+2 or N+3.
- R8: When `pass_en` is high and `rst` is low, all four lanes output, one cycle later, the `pass_*` stream values from the cycle before.
- R9: While `rst` is high, both streams of every data lane are 0 from the next edge onward, and the clock lane keeps its R6 pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate bit clock, 3.5 cycles per pixel |
| rst | input | 1 | Synchronous reset, active high |
| pix_red | input | CBITS | Red channel |
| pix_grn | input | CBITS | Green channel |
| pix_blu | input | CBITS | Blue channel |
| line_sync | input | 1 | Horizontal sync level |
| frame_sync | input | 1 | Vertical sync level |
| active | input | 1 | Visible-pixel flag |
| map_sel | input | 1 | Lane mapping choice, sampled with the word |
| pass_en | input | 1 | Forward received streams instead of serializing |
| pass_rise | input | LANES | Received rising-edge data streams |
| pass_fall | input | LANES | Received falling-edge data streams |
| pass_clk_rise | input | 1 | Received clock-lane rising stream |
| pass_clk_fall | input | 1 | Received clock-lane falling stream |
| word_take | output | 1 | Parallel inputs latched at the end of this cycle |
| lane_rise | output | LANES | Rising-edge data streams |
| lane_fall | output | LANES | Falling-edge data streams |
| clk_rise | output | 1 | Clock-lane rising stream |
| clk_fall | output | 1 | Clock-lane falling stream |

## Verification
The clock-lane periodicity property assumes `pass_en` has stayed low, or reset has been held, for at least nine cycles. The bench therefore enables pass-through only after all decoded data has been captured. The forwarding property assumes the `pass_*` inputs change only between edges, so the bench drives them at the falling clock edge. The take-spacing properties assume nothing about the inputs. Decoding relies on the bench changing the parallel inputs away from the take edges, and the bench drives inverted garbage words and a flipped `map_sel` in every non-take cycle to show that they are never sampled.

// File: rtl/pix7_pkg.sv
package pix7_pkg;

    localparam int SLOT_BITS = 7;

    // Clock-lane level for slot bit positions 6..0 (bit 0 sent first).
    localparam logic [SLOT_BITS-1:0] CLK_SLOT_PAT = 7'b1100011;

    // Phase within a two-pixel group of seven half-rate cycles.
    typedef enum logic [2:0] {
        PH0 = 3'd0,
        PH1 = 3'd1,
        PH2 = 3'd2,
        PH3 = 3'd3,
        PH4 = 3'd4,
        PH5 = 3'd5,
        PH6 = 3'd6
    } phase_e;

    function automatic int flat_width(input int cbits);
        return 3 * cbits + 3;
    endfunction

    function automatic int lane_count(input int cbits);
        return (flat_width(cbits) + SLOT_BITS - 1) / SLOT_BITS;
    endfunction

endpackage

// File: rtl/pix7_phase_fsm.sv
module pix7_phase_fsm
    import pix7_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase,
    output logic   load_a,
    output logic   load_b,
    output logic   take,
    output logic   clk_bit_r,
    output logic   clk_bit_f
);

    phase_e phase_nx;

    // Free-running on purpose: the clock lane must keep toggling in reset.
    always_ff @(posedge clk) begin
        phase <= phase_nx;
    end

    always_comb begin
        unique case (phase)
            PH0:     phase_nx = PH1;
            PH1:     phase_nx = PH2;
            PH2:     phase_nx = PH3;
            PH3:     phase_nx = PH4;
            PH4:     phase_nx = PH5;
            PH5:     phase_nx = PH6;
            PH6:     phase_nx = PH0;
            default: phase_nx = PH0;
        endcase
    end

    // Outputs: word loads and the clock-lane bits for serial index 2k, 2k+1.
    always_comb begin
        load_a    = 1'b0;
        load_b    = 1'b0;
        clk_bit_r = 1'b0;
        clk_bit_f = 1'b0;
        unique case (phase)
            PH0: begin
                clk_bit_r = CLK_SLOT_PAT[0];
                clk_bit_f = CLK_SLOT_PAT[1];
            end
            PH1: begin
                clk_bit_r = CLK_SLOT_PAT[2];
                clk_bit_f = CLK_SLOT_PAT[3];
            end
            PH2: begin
                load_b    = !rst;
                clk_bit_r = CLK_SLOT_PAT[4];
                clk_bit_f = CLK_SLOT_PAT[5];
            end
            PH3: begin
                clk_bit_r = CLK_SLOT_PAT[6];
                clk_bit_f = CLK_SLOT_PAT[0];
            end
            PH4: begin
                clk_bit_r = CLK_SLOT_PAT[1];
                clk_bit_f = CLK_SLOT_PAT[2];
            end
            PH5: begin
                clk_bit_r = CLK_SLOT_PAT[3];
                clk_bit_f = CLK_SLOT_PAT[4];
            end
            PH6: begin
                load_a    = !rst;
                clk_bit_r = CLK_SLOT_PAT[5];
                clk_bit_f = CLK_SLOT_PAT[6];
            end
            default: begin
                load_a    = 1'b0;
                load_b    = 1'b0;
            end
        endcase
        take = load_a | load_b;
    end

endmodule

// File: rtl/pix7_lane_map.sv
module pix7_lane_map
    import pix7_pkg::*;
#(
    parameter int CBITS = 6,
    parameter int LANES = lane_count(CBITS)
) (
    input  logic [CBITS-1:0]                   red,
    input  logic [CBITS-1:0]                   grn,
    input  logic [CBITS-1:0]                   blu,
    input  logic                               hs,
    input  logic                               vs,
    input  logic                               de,
    input  logic                               sel,
    output logic [LANES-1:0][SLOT_BITS-1:0]    words
);

    localparam int FW = flat_width(CBITS);

    logic [FW-1:0]                  flat;
    logic [LANES-1:0][SLOT_BITS-1:0] w_fwd;
    logic [LANES-1:0][SLOT_BITS-1:0] w_rev;

    assign flat = {de, vs, hs, blu, grn, red};

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        for (genvar k = 0; k < SLOT_BITS; k++) begin : g_bit
            localparam int IDX_F = SLOT_BITS * ln + k;
            localparam int IDX_R = SLOT_BITS * ln + (SLOT_BITS - 1 - k);
            if (IDX_F < FW) begin : g_f
                assign w_fwd[ln][k] = flat[IDX_F];
            end else begin : g_fpad
                assign w_fwd[ln][k] = 1'b0;
            end
            if (IDX_R < FW) begin : g_r
                assign w_rev[ln][k] = flat[IDX_R];
            end else begin : g_rpad
                assign w_rev[ln][k] = 1'b0;
            end
        end
    end

    assign words = sel ? w_rev : w_fwd;

endmodule

// File: rtl/pix7_lane_ser.sv
module pix7_lane_ser
    import pix7_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  phase_e               phase,
    input  logic                 load_a,
    input  logic                 load_b,
    input  logic [SLOT_BITS-1:0] word_in,
    input  logic                 pass_en,
    input  logic                 pass_r,
    input  logic                 pass_f,
    output logic                 rise_q,
    output logic                 fall_q
);

    logic [SLOT_BITS-1:0] word_a;
    logic [SLOT_BITS-1:0] word_b;
    logic                 pick_r;
    logic                 pick_f;

    // Serial index 2k and 2k+1 of the 14-bit group {word_b, word_a}.
    always_comb begin
        pick_r = 1'b0;
        pick_f = 1'b0;
        unique case (phase)
            PH0: begin pick_r = word_a[0]; pick_f = word_a[1]; end
            PH1: begin pick_r = word_a[2]; pick_f = word_a[3]; end
            PH2: begin pick_r = word_a[4]; pick_f = word_a[5]; end
            PH3: begin pick_r = word_a[6]; pick_f = word_b[0]; end
            PH4: begin pick_r = word_b[1]; pick_f = word_b[2]; end
            PH5: begin pick_r = word_b[3]; pick_f = word_b[4]; end
            PH6: begin pick_r = word_b[5]; pick_f = word_b[6]; end
            default: begin pick_r = 1'b0; pick_f = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_a <= '0;
            word_b <= '0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            if (load_a) word_a <= word_in;
            if (load_b) word_b <= word_in;
            rise_q <= pass_en ? pass_r : pick_r;
            fall_q <= pass_en ? pass_f : pick_f;
        end
    end

endmodule

// File: rtl/pix7_serializer.sv
module pix7_serializer
    import pix7_pkg::*;
#(
    parameter  int CBITS = 6,
    localparam int LANES = lane_count(CBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CBITS-1:0] pix_red,
    input  logic [CBITS-1:0] pix_grn,
    input  logic [CBITS-1:0] pix_blu,
    input  logic             line_sync,
    input  logic             frame_sync,
    input  logic             active,
    input  logic             map_sel,
    input  logic             pass_en,
    input  logic [LANES-1:0] pass_rise,
    input  logic [LANES-1:0] pass_fall,
    input  logic             pass_clk_rise,
    input  logic             pass_clk_fall,
    output logic             word_take,
    output logic [LANES-1:0] lane_rise,
    output logic [LANES-1:0] lane_fall,
    output logic             clk_rise,
    output logic             clk_fall
);

    phase_e                           phase;
    logic                             load_a;
    logic                             load_b;
    logic                             gen_clk_r;
    logic                             gen_clk_f;
    logic [LANES-1:0][SLOT_BITS-1:0]  words;

    pix7_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .load_a    (load_a),
        .load_b    (load_b),
        .take      (word_take),
        .clk_bit_r (gen_clk_r),
        .clk_bit_f (gen_clk_f)
    );

    pix7_lane_map #(.CBITS(CBITS), .LANES(LANES)) u_map (
        .red   (pix_red),
        .grn   (pix_grn),
        .blu   (pix_blu),
        .hs    (line_sync),
        .vs    (frame_sync),
        .de    (active),
        .sel   (map_sel),
        .words (words)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_data
        pix7_lane_ser u_lane (
            .clk     (clk),
            .rst     (rst),
            .phase   (phase),
            .load_a  (load_a),
            .load_b  (load_b),
            .word_in (words[ln]),
            .pass_en (pass_en),
            .pass_r  (pass_rise[ln]),
            .pass_f  (pass_fall[ln]),
            .rise_q  (lane_rise[ln]),
            .fall_q  (lane_fall[ln])
        );
    end

    // Clock lane: generated pattern, forwarded only outside reset.
    always_ff @(posedge clk) begin
        clk_rise <= (pass_en && !rst) ? pass_clk_rise : gen_clk_r;
        clk_fall <= (pass_en && !rst) ? pass_clk_fall : gen_clk_f;
    end

endmodule

// File: rtl/pix7_serializer_chk.sv
module pix7_serializer_chk #(
    parameter int LANES = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             word_take,
    input logic             pass_en,
    input logic [LANES-1:0] pass_rise,
    input logic [LANES-1:0] pass_fall,
    input logic             pass_clk_rise,
    input logic             pass_clk_fall,
    input logic [LANES-1:0] lane_rise,
    input logic [LANES-1:0] lane_fall,
    input logic             clk_rise,
    input logic             clk_fall
);

    logic [3:0] cyc     = 4'd0;
    logic [3:0] gen_run = 4'd0;

    always_ff @(posedge clk) begin
        if (cyc != 4'hF) cyc <= cyc + 4'd1;
        if (rst || !pass_en) begin
            if (gen_run != 4'hF) gen_run <= gen_run + 4'd1;
        end else begin
            gen_run <= 4'd0;
        end
    end

    AST_RST_DATA_ZERO: assert property (@(posedge clk) rst |=> (lane_rise == '0 && lane_fall == '0)); // R9

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst) word_take |=> !word_take); // R2

    AST_TAKE_GAP: assert property (@(posedge clk) disable iff (rst) (cyc >= 4'd3 && word_take) |-> (!$past(word_take, 1) && !$past(word_take, 2))); // R2

    AST_CLK_PERIODIC: assert property (@(posedge clk) (gen_run >= 4'd9) |-> (clk_rise == $past(clk_rise, 7) && clk_fall == $past(clk_fall, 7))); // R6

    AST_PASS_FORWARD: assert property (@(posedge clk) disable iff (rst) pass_en |=> (lane_rise == $past(pass_rise) && lane_fall == $past(pass_fall) && clk_rise == $past(pass_clk_rise) && clk_fall == $past(pass_clk_fall))); // R8

endmodule

bind pix7_serializer pix7_serializer_chk #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .word_take     (word_take),
    .pass_en       (pass_en),
    .pass_rise     (pass_rise),
    .pass_fall     (pass_fall),
    .pass_clk_rise (pass_clk_rise),
    .pass_clk_fall (pass_clk_fall),
    .lane_rise     (lane_rise),
    .lane_fall     (lane_fall),
    .clk_rise      (clk_rise),
    .clk_fall      (clk_fall)
);

// File: tb/pix7_serializer_tb_top.sv
`timescale 1ns/1ps
module pix7_serializer_tb_top;

    localparam int CB   = 6;
    localparam int NL   = 3;
    localparam int CAPN = 2048;
    localparam int NV   = 12;

    // Stimulus: bit 21 = map select, bits 20:0 = flat word F (see R3).
    localparam logic [21:0] VEC [NV] = '{
        22'h000001, 22'h100000, 22'h0AAAAA, 22'h155555,
        22'h200001, 22'h3FFFFE, 22'h012345, 22'h21E0F0,
        22'h1C0707, 22'h300040, 22'h0F00FF, 22'h2ABCDE
    };
    localparam logic [6:0] CPAT = 7'b1100011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CB-1:0] pix_red = '0, pix_grn = '0, pix_blu = '0;
    logic line_sync = 1'b0, frame_sync = 1'b0, active = 1'b0;
    logic map_sel = 1'b0, pass_en = 1'b0;
    logic [NL-1:0] pass_rise = '0, pass_fall = '0;
    logic pass_clk_rise = 1'b0, pass_clk_fall = 1'b0;
    logic word_take;
    logic [NL-1:0] lane_rise, lane_fall;
    logic clk_rise, clk_fall;

    always #2 clk = ~clk;

    pix7_serializer #(.CBITS(CB)) dut_i (
        .clk(clk), .rst(rst), .pix_red(pix_red), .pix_grn(pix_grn),
        .pix_blu(pix_blu), .line_sync(line_sync), .frame_sync(frame_sync),
        .active(active), .map_sel(map_sel), .pass_en(pass_en),
        .pass_rise(pass_rise), .pass_fall(pass_fall),
        .pass_clk_rise(pass_clk_rise), .pass_clk_fall(pass_clk_fall),
        .word_take(word_take), .lane_rise(lane_rise), .lane_fall(lane_fall),
        .clk_rise(clk_rise), .clk_fall(clk_fall)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic ser  [NL][CAPN];
    logic cser [CAPN];
    int   ncap = 0;
    int   cyc  = 0;
    int   take_cyc [64];
    int   ntake = 0;
    int   lbits [NV];

    // Sample just after each rising edge, away from input changes.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (ncap < CAPN - 2) begin
            for (int l = 0; l < NL; l++) begin
                ser[l][ncap]     = lane_rise[l];
                ser[l][ncap + 1] = lane_fall[l];
            end
            cser[ncap]     = clk_rise;
            cser[ncap + 1] = clk_fall;
            ncap += 2;
        end
        if (word_take && !rst && ntake < 64) begin
            take_cyc[ntake] = cyc;
            ntake++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_word(input logic [20:0] f, input logic sel, input int lane);
        logic [6:0] w;
        for (int k = 0; k < 7; k++)
            w[k] = sel ? f[7 * lane + 6 - k] : f[7 * lane + k];
        return w;
    endfunction

    task automatic drive_word(input logic [21:0] v);
        {map_sel, active, frame_sync, line_sync, pix_blu, pix_grn, pix_red} = v;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    int bad;
    int s_prev;
    int s_cur;
    int s0;
    int nend;

    initial begin
        // Reset: data lanes zero and no take (R9).
        bad = 0;
        repeat (12) begin
            @(negedge clk);
            if (lane_rise != '0 || lane_fall != '0 || word_take) bad++;
        end
        chk("R9 data lanes zero and no take in reset", bad, 0);

        // Table walk: one word per take, garbage elsewhere (R5).
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            do begin
                @(negedge clk);
                if (!word_take) drive_word(~VEC[i]);
            end while (!word_take);
            drive_word(VEC[i]);
            lbits[i] = ncap;
        end
        @(negedge clk);
        drive_word(22'h3FFFFF);
        repeat (10) @(negedge clk);
        nend = ncap;

        // Decode slots from the clock lane (R6, R7, R3, R4, R5, R1).
        s_prev = -1;
        s0 = 0;
        for (int i = 0; i < NV; i++) begin
            logic [20:0] act_w;
            logic [20:0] exp_w;
            s_cur = lbits[i] + 2;
            while (s_cur < nend && !(cser[s_cur - 3] == 1'b0 && cser[s_cur - 2] == 1'b1)) s_cur++;
            if (i == 0) s0 = s_cur;
            chk($sformatf("R7 slot start offset word %0d", i), s_cur - lbits[i] <= 3, 1);
            for (int l = 0; l < NL; l++)
                for (int k = 0; k < 7; k++) begin
                    act_w[7 * l + k] = ser[l][s_cur + k];
                    exp_w[7 * l + k] = exp_word(VEC[i][20:0], VEC[i][21], l)[k];
                end
            if (VEC[i][21])
                chk($sformatf("R4 R5 reversed map word %0d", i), act_w, exp_w);
            else
                chk($sformatf("R3 R5 direct map word %0d", i), act_w, exp_w);
            if (s_prev >= 0) begin
                chk($sformatf("R1 slot spacing word %0d", i), s_cur - s_prev, 7);
                chk($sformatf("R1 start stream alternates word %0d", i), (s_cur % 2) != (s_prev % 2), 1);
            end
            s_prev = s_cur;
        end

        // Clock lane pattern through reset and run (R6, R9).
        bad = 0;
        for (int n = 4; n < nend; n++)
            if (cser[n] !== CPAT[((n - s0) % 7 + 7) % 7]) bad++;
        chk("R6 R9 clock lane pattern", bad, 0);

        // Take spacing (R2).
        bad = 0;
        for (int t = 2; t < ntake; t++) begin
            int d1;
            int d0;
            d1 = take_cyc[t] - take_cyc[t - 1];
            d0 = take_cyc[t - 1] - take_cyc[t - 2];
            if (!((d1 == 3 && d0 == 4) || (d1 == 4 && d0 == 3))) bad++;
        end
        chk("R2 take spacing alternates 3 and 4", bad, 0);
        chk("R2 takes observed", ntake >= NV, 1);

        // Pass-through forwarding, parallel input ignored (R8).
        @(negedge clk);
        pass_en = 1'b1;
        for (int p = 0; p < 6; p++) begin
            logic [7:0] pv;
            pv = 8'h5A ^ (8'h27 * p[7:0]);
            {pass_clk_fall, pass_clk_rise, pass_fall, pass_rise} = pv;
            drive_word({pv[5:0], pv, pv});
            @(negedge clk);
            chk($sformatf("R8 forwarded streams pattern %0d", p),
                {clk_fall, clk_rise, lane_fall, lane_rise}, pv);
        end

        // Reset during pass-through zeroes data lanes (R9).
        rst = 1'b1;
        pass_rise = '1;
        pass_fall = '1;
        @(negedge clk);
        chk("R9 reset overrides pass-through data", {lane_fall, lane_rise}, 6'h00);
        chk("R9 no take in reset", word_take, 1'b0);
        @(negedge clk);
        chk("R9 data held zero in reset", {lane_fall, lane_rise}, 6'h00);

        done = 1'b1;
        finish_run();
    end

endmodule